// File: doc/BRIEF.md
# Conditional Move Condition Evaluator

This block decides whether a conditional register move should take effect. It works in one of two modes. In flag mode it tests one of two integer condition-code sets, using the negative, zero, overflow and carry flags to judge signed and unsigned conditions. In register mode it looks at a 64-bit integer register value and tests whether it is zero, negative, or zero-or-negative. Each mode has its own condition field and its own inversion bit.

The caller fetches the register operand and performs the move. It supplies the instruction word, the condition-code byte, the operand and the mode, with a valid strobe. The single output says whether the move is taken. The path is purely combinational, with no state, so the decision is ready in the same cycle as its inputs.

Top module: `cmov_cond_eval`

## Requirements
- R1: `take_o` is 0 in every cycle where `valid_i` is 0, whatever the other inputs are.
- R2: In flag mode, instruction bit 12 set selects the upper nibble `ccr_i[7:4]` (the 64-bit set), and clear selects `ccr_i[3:0]` (the 32-bit set). Within a nibble, bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C.
- R3: In flag mode the condition code in instruction bits 16:14 means: 0 never, 1 Z, 2 Z or (N xor V), 3 N xor V, 4 C or Z, 5 C, 6 N, 7 V.
- R4: Instruction bit 17 inverts the flag-mode result. Code 0 with bit 17 set is therefore always taken.
- R5: In register mode the condition code in instruction bits 11:10 means: 0 never, 1 operand equals zero, 2 operand is at most zero (signed), 3 operand is below zero (signed).
- R6: In register mode, instruction bit 12 inverts the result. Code 0 with bit 12 set is always taken.
- R7: In register mode, a register specifier of 0 in instruction bits 18:14 makes the operand read as zero, and `reg_val_i` is ignored.
- R8: In flag mode, `reg_val_i` and instruction bits 11:10 have no effect on `take_o`. In register mode, `ccr_i` has no effect.
- R9: `mode_i` = 0 selects flag mode and `mode_i` = 1 selects register mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid_i | input | 1 | Qualifies the request; the decision is forced to not-taken when low |
| mode_i | input | 1 | 0 tests condition flags, 1 tests the register operand |
| insn_i | input | 32 | Instruction word carrying the condition, inversion and selector fields |
| ccr_i | input | 8 | Two condition-code nibbles: upper is the 64-bit set, lower is the 32-bit set |
| reg_val_i | input | 64 | Register operand tested in register mode |
| take_o | output | 1 | 1 when the conditional move is to be performed |

## Verification
The assertions guard properties that hold in every evaluation:
- the output is quiet while the request is not valid;
- the "never" code gives not-taken unless inverted, and "always" when inverted;
- an "equal" hit implies the selected Z flag is set;
- a zero specifier can never yield "negative", and it always satisfies "at most zero".

The full condition tables are shown only by the bench's directed and random scenarios, compared against its own model:
- the signed comparisons at the sign boundary;
- the choice between the two flag nibbles;
- the fact that the inputs of the unselected mode are ignored.

// File: rtl/cmov_cond_pkg.sv
`timescale 1ns/1ps
package cmov_cond_pkg;

    localparam int unsigned INSN_W  = 32;
    localparam int unsigned FLAG_W  = 4;
    localparam int unsigned CC_SETS = 2;
    localparam int unsigned SPEC_W  = 5;

    // field positions that the decode depends on
    localparam int unsigned ICC_INV_BIT  = 17;
    localparam int unsigned ICC_CODE_LSB = 14;
    localparam int unsigned ICC_SET_BIT  = 12;
    localparam int unsigned RC_SPEC_LSB  = 14;
    localparam int unsigned RC_INV_BIT   = 12;
    localparam int unsigned RC_CODE_LSB  = 10;

    typedef enum logic {
        MODE_FLAGS = 1'b0,
        MODE_REG   = 1'b1
    } cmov_mode_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef enum logic [2:0] {
        IC_NEVER = 3'd0,
        IC_EQ    = 3'd1,
        IC_LE    = 3'd2,
        IC_LT    = 3'd3,
        IC_LEU   = 3'd4,
        IC_CS    = 3'd5,
        IC_NEG   = 3'd6,
        IC_VS    = 3'd7
    } icc_code_e;

    typedef enum logic [1:0] {
        RC_NEVER = 2'd0,
        RC_ZERO  = 2'd1,
        RC_LEZ   = 2'd2,
        RC_LTZ   = 2'd3
    } rcond_e;

    typedef struct packed {
        logic      invert;
        icc_code_e code;
        logic      hi_set;
    } icc_fields_t;

    typedef struct packed {
        logic [SPEC_W-1:0] spec;
        logic              invert;
        rcond_e            code;
    } reg_fields_t;

    function automatic icc_fields_t decode_icc(input logic [INSN_W-1:0] insn);
        icc_fields_t f;
        f.invert = insn[ICC_INV_BIT];
        f.code   = icc_code_e'(insn[ICC_CODE_LSB +: 3]);
        f.hi_set = insn[ICC_SET_BIT];
        return f;
    endfunction

    function automatic reg_fields_t decode_reg(input logic [INSN_W-1:0] insn);
        reg_fields_t f;
        f.spec   = insn[RC_SPEC_LSB +: SPEC_W];
        f.invert = insn[RC_INV_BIT];
        f.code   = rcond_e'(insn[RC_CODE_LSB +: 2]);
        return f;
    endfunction

    function automatic logic icc_test(input flags_t fl, input icc_code_e code);
        logic r;
        unique case (code)
            IC_NEVER: r = 1'b0;
            IC_EQ:    r = fl.z;
            IC_LE:    r = fl.z | (fl.n ^ fl.v);
            IC_LT:    r = fl.n ^ fl.v;
            IC_LEU:   r = fl.c | fl.z;
            IC_CS:    r = fl.c;
            IC_NEG:   r = fl.n;
            IC_VS:    r = fl.v;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic reg_test(input logic is_zero, input logic is_neg,
                                      input rcond_e code);
        logic r;
        unique case (code)
            RC_NEVER: r = 1'b0;
            RC_ZERO:  r = is_zero;
            RC_LEZ:   r = is_zero | is_neg;
            RC_LTZ:   r = is_neg;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cmov_flag_eval.sv
`timescale 1ns/1ps
module cmov_flag_eval
    import cmov_cond_pkg::*;
#(
    parameter int unsigned SETS = CC_SETS
) (
    input  icc_fields_t               fields_i,
    input  logic [SETS*FLAG_W-1:0]    ccr_i,
    output logic                      hit_o
);

    localparam int unsigned SEL_W = (SETS > 1) ? $clog2(SETS) : 1;

    logic [SETS-1:0] set_hit;
    logic [SEL_W-1:0] set_sel;
    flags_t           sel_flags;

    // one evaluator per condition-code set
    for (genvar g = 0; g < SETS; g++) begin : g_set
        flags_t fl;
        assign fl         = flags_t'(ccr_i[g*FLAG_W +: FLAG_W]);
        assign set_hit[g] = icc_test(fl, fields_i.code);
    end

    assign set_sel   = SEL_W'(fields_i.hi_set);
    assign sel_flags = flags_t'(ccr_i[set_sel*FLAG_W +: FLAG_W]);
    assign hit_o     = set_hit[set_sel] ^ fields_i.invert;

    always_comb begin
        // R4
        never_quiet_chk: assert (!(fields_i.code == IC_NEVER && !fields_i.invert) || !hit_o)
            else $error("never code produced a hit");
        // R4
        never_inv_chk: assert (!(fields_i.code == IC_NEVER && fields_i.invert) || hit_o)
            else $error("inverted never code did not hit");
        // R3
        eq_needs_z_chk: assert (!(fields_i.code == IC_EQ && !fields_i.invert && hit_o) || sel_flags.z)
            else $error("equal hit without Z");
    end

endmodule

// File: rtl/cmov_reg_eval.sv
`timescale 1ns/1ps
module cmov_reg_eval
    import cmov_cond_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  reg_fields_t        fields_i,
    input  logic [DATA_W-1:0]  reg_val_i,
    output logic               hit_o
);

    logic [DATA_W-1:0] operand;
    logic              is_zero;
    logic              is_neg;
    logic              spec_zero;

    assign spec_zero = (fields_i.spec == '0);
    assign operand   = spec_zero ? '0 : reg_val_i;
    assign is_zero   = ~|operand;
    assign is_neg    = operand[DATA_W-1];
    assign hit_o     = reg_test(is_zero, is_neg, fields_i.code) ^ fields_i.invert;

    always_comb begin
        // R7
        zero_spec_not_neg_chk: assert (!(spec_zero && fields_i.code == RC_LTZ && !fields_i.invert) || !hit_o)
            else $error("zero specifier judged negative");
        // R5
        zero_spec_lez_chk: assert (!(spec_zero && fields_i.code == RC_LEZ && !fields_i.invert) || hit_o)
            else $error("zero specifier failed at-most-zero");
        // R6
        reg_never_chk: assert (!(fields_i.code == RC_NEVER) || (hit_o == fields_i.invert))
            else $error("register never code mismatch");
    end

endmodule

// File: rtl/cmov_cond_eval.sv
`timescale 1ns/1ps
module cmov_cond_eval
    import cmov_cond_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned IW     = INSN_W,
    localparam int unsigned CCR_W = CC_SETS * FLAG_W
) (
    input  logic              valid_i,
    input  logic              mode_i,
    input  logic [IW-1:0]     insn_i,
    input  logic [CCR_W-1:0]  ccr_i,
    input  logic [DATA_W-1:0] reg_val_i,
    output logic              take_o
);

    icc_fields_t icc_f;
    reg_fields_t reg_f;
    cmov_mode_e  mode;
    logic        flag_hit;
    logic        reg_hit;
    logic        sel_hit;

    assign icc_f = decode_icc(INSN_W'(insn_i));
    assign reg_f = decode_reg(INSN_W'(insn_i));
    assign mode  = cmov_mode_e'(mode_i);

    cmov_flag_eval #(
        .SETS (CC_SETS)
    ) u_flag (
        .fields_i (icc_f),
        .ccr_i    (ccr_i),
        .hit_o    (flag_hit)
    );

    cmov_reg_eval #(
        .DATA_W (DATA_W)
    ) u_reg (
        .fields_i  (reg_f),
        .reg_val_i (reg_val_i),
        .hit_o     (reg_hit)
    );

    always_comb begin
        unique case (mode)
            MODE_FLAGS: sel_hit = flag_hit;
            MODE_REG:   sel_hit = reg_hit;
            default:    sel_hit = 1'b0;
        endcase
    end

    assign take_o = valid_i & sel_hit;

    always_comb begin
        // R1
        idle_quiet_chk: assert (valid_i || !take_o)
            else $error("take asserted without valid");
        // R9
        take_source_chk: assert (!take_o || (mode == MODE_REG ? reg_hit : flag_hit))
            else $error("take from unselected mode");
    end

endmodule

// File: tb/tb_cmov_cond_eval.sv
`timescale 1ns/1ps
module tb_cmov_cond_eval;

    logic        clk = 1'b0;
    logic        valid_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic [7:0]  ccr_i = '0;
    logic [63:0] reg_val_i = '0;
    logic        take_o;

    int unsigned total = 0;
    int unsigned fails = 0;

    always #10 clk = ~clk;

    cmov_cond_eval dut (
        .valid_i   (valid_i),
        .mode_i    (mode_i),
        .insn_i    (insn_i),
        .ccr_i     (ccr_i),
        .reg_val_i (reg_val_i),
        .take_o    (take_o)
    );

    function automatic logic [31:0] mk_flag(input logic inv, input logic [2:0] code,
                                            input logic upper);
        logic [31:0] w = 32'h0;
        w[17] = inv; w[16:14] = code; w[12] = upper;
        return w;
    endfunction

    function automatic logic [31:0] mk_reg(input logic [4:0] spec, input logic inv,
                                           input logic [1:0] code);
        logic [31:0] w = 32'h0;
        w[18:14] = spec; w[12] = inv; w[11:10] = code;
        return w;
    endfunction

    function automatic logic model(input logic v, input logic m, input logic [31:0] i,
                                   input logic [7:0] cc, input logic [63:0] r);
        logic [3:0] nib;
        logic       t;
        logic [63:0] val;
        if (!v) return 1'b0;
        t = 1'b0;
        if (!m) begin
            nib = i[12] ? cc[7:4] : cc[3:0];
            case (i[16:14])
                3'd1: t = nib[2];
                3'd2: t = nib[2] || (nib[3] != nib[1]);
                3'd3: t = (nib[3] != nib[1]);
                3'd4: t = nib[0] || nib[2];
                3'd5: t = nib[0];
                3'd6: t = nib[3];
                3'd7: t = nib[1];
                default: t = 1'b0;
            endcase
            if (i[17]) t = !t;
        end else begin
            val = (i[18:14] == 5'd0) ? 64'd0 : r;
            case (i[11:10])
                2'd1: t = (val == 64'd0);
                2'd2: t = ($signed(val) <= 64'sd0);
                2'd3: t = ($signed(val) < 64'sd0);
                default: t = 1'b0;
            endcase
            if (i[12]) t = !t;
        end
        return t;
    endfunction

    task automatic drive(input logic v, input logic m, input logic [31:0] i,
                         input logic [7:0] cc, input logic [63:0] r);
        @(negedge clk);
        valid_i = v; mode_i = m; insn_i = i; ccr_i = cc; reg_val_i = r;
        #5;
    endtask

    task automatic check(input string req, input logic exp);
        total++;
        if (take_o !== exp) begin
            fails++;
            $display("FAIL %s: take_o=%b expected=%b (mode=%b insn=%h ccr=%h reg=%h)",
                     req, take_o, exp, mode_i, insn_i, ccr_i, reg_val_i);
        end
    endtask

    task automatic run(input string req, input logic v, input logic m, input logic [31:0] i,
                       input logic [7:0] cc, input logic [63:0] r);
        drive(v, m, i, cc, r);
        check(req, model(v, m, i, cc, r));
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        total++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] ri;
        logic [63:0] rv;
        void'($urandom(32'h1c3d_5a7e));

        // R1 idle state and valid gating of an always-true condition
        #5;
        check("R1 initial idle", 1'b0);
        drive(1'b0, 1'b0, mk_flag(1'b1, 3'd0, 1'b0), 8'hff, 64'h0);
        check("R1 valid low blocks always", 1'b0);
        drive(1'b1, 1'b0, mk_flag(1'b1, 3'd0, 1'b0), 8'h00, 64'h0);
        check("R4 inverted never is always", 1'b1);
        drive(1'b1, 1'b0, mk_flag(1'b0, 3'd0, 1'b0), 8'hff, 64'h0);
        check("R4 never", 1'b0);

        // R2 nibble selection: Z only in upper set
        drive(1'b1, 1'b0, mk_flag(1'b0, 3'd1, 1'b1), 8'h40, 64'h0);
        check("R2 upper set Z", 1'b1);
        drive(1'b1, 1'b0, mk_flag(1'b0, 3'd1, 1'b0), 8'h40, 64'h0);
        check("R2 lower set lacks Z", 1'b0);

        // R3 every code against every lower nibble
        for (int c = 0; c < 8; c++) begin
            for (int f = 0; f < 16; f++) begin
                run("R3 flag table", 1'b1, 1'b0, mk_flag(1'b0, 3'(c), 1'b0), {4'h0, 4'(f)}, 64'h0);
                run("R4 flag inverted", 1'b1, 1'b0, mk_flag(1'b1, 3'(c), 1'b1), {4'(f), 4'h0}, 64'h0);
            end
        end
        drive(1'b1, 1'b0, mk_flag(1'b0, 3'd3, 1'b0), 8'h08, 64'h0);
        check("R3 less when N set V clear", 1'b1);
        drive(1'b1, 1'b0, mk_flag(1'b0, 3'd3, 1'b0), 8'h0a, 64'h0);
        check("R3 not less when N equals V", 1'b0);

        // R5 sign boundaries
        drive(1'b1, 1'b1, mk_reg(5'd3, 1'b0, 2'd2), 8'h00, 64'h0);
        check("R5 zero at most zero", 1'b1);
        drive(1'b1, 1'b1, mk_reg(5'd3, 1'b0, 2'd3), 8'h00, 64'h0);
        check("R5 zero not below zero", 1'b0);
        drive(1'b1, 1'b1, mk_reg(5'd3, 1'b0, 2'd3), 8'h00, 64'h8000_0000_0000_0000);
        check("R5 most negative below zero", 1'b1);
        drive(1'b1, 1'b1, mk_reg(5'd3, 1'b0, 2'd2), 8'h00, 64'h7fff_ffff_ffff_ffff);
        check("R5 most positive not at most zero", 1'b0);
        drive(1'b1, 1'b1, mk_reg(5'd3, 1'b0, 2'd1), 8'h00, 64'h0000_0001_0000_0000);
        check("R5 high bit nonzero", 1'b0);

        // R6 inversion
        drive(1'b1, 1'b1, mk_reg(5'd3, 1'b1, 2'd1), 8'h00, 64'h5);
        check("R6 inverted zero test", 1'b1);
        drive(1'b1, 1'b1, mk_reg(5'd3, 1'b1, 2'd0), 8'h00, 64'h5);
        check("R6 inverted never", 1'b1);

        // R7 specifier zero reads zero
        drive(1'b1, 1'b1, mk_reg(5'd0, 1'b0, 2'd3), 8'h00, 64'hffff_ffff_ffff_ffff);
        check("R7 spec zero not negative", 1'b0);
        drive(1'b1, 1'b1, mk_reg(5'd0, 1'b0, 2'd1), 8'h00, 64'h1234);
        check("R7 spec zero is zero", 1'b1);

        // R8 unselected inputs have no effect
        drive(1'b1, 1'b0, mk_flag(1'b0, 3'd5, 1'b0) | 32'h0000_0c00, 8'h01, 64'hffff_ffff_ffff_ffff);
        check("R8 flag mode ignores reg", 1'b1);
        drive(1'b1, 1'b0, mk_flag(1'b0, 3'd5, 1'b0), 8'h01, 64'h0);
        check("R8 flag mode ignores reg alt", 1'b1);
        drive(1'b1, 1'b1, mk_reg(5'd3, 1'b0, 2'd1), 8'hff, 64'h0);
        check("R8 reg mode ignores ccr", 1'b1);
        drive(1'b1, 1'b1, mk_reg(5'd3, 1'b0, 2'd1), 8'h00, 64'h0);
        check("R8 reg mode ignores ccr alt", 1'b1);

        // R9 same word, different mode
        drive(1'b1, 1'b0, mk_reg(5'd3, 1'b0, 2'd1), 8'h00, 64'h0);
        check("R9 flag mode chosen", 1'b0);
        drive(1'b1, 1'b1, mk_reg(5'd3, 1'b0, 2'd1), 8'h00, 64'h0);
        check("R9 register mode chosen", 1'b1);

        // random mix
        for (int n = 0; n < 600; n++) begin
            ri = $urandom;
            rv = {$urandom, $urandom};
            if (n % 7 == 0) rv = 64'h0;
            if (n % 11 == 0) rv = 64'hffff_ffff_ffff_ffff;
            if (n % 2 == 0)
                run("R3 random flag", (n % 13) != 0, 1'b0, ri, 8'($urandom), rv);
            else
                run("R5 random reg", (n % 13) != 0, 1'b1, ri, 8'($urandom), rv);
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule